// File: doc/BRIEF.md
# Lite Timer with Edge Capture and Watchdog

This block is a small timer peripheral reached over a simple single-cycle register bus. A prescaler divides the input clock by 32 to step an 8-bit up-counter. The counter wraps after 250 steps, and each wrap drives a timebase event with one of two periods. A synchronised input pin snapshots the counter on either edge into a read-only capture register. A watchdog counts fixed periods and asks the reset controller for a reset, and it keeps a sticky flag that tells software why the last reset happened.

Flags clear when their register is read, not when it is written. A pending capture blocks any new capture until software reads the captured value. One status bit is both the software command that forces a reset and the hardware flag that reports one. Two reset inputs exist:
- the system reset returns everything to its reset state except the reset-cause flag;
- the low-voltage reset clears only that flag.

The bus has no data stream and no back-pressure. Every access completes in the cycle `bus_sel` is high. Read data is combinational from the address, and read side effects take place at the clock edge that ends the access.

Top module: `lite_timer_wdg`

## Requirements
- R1: After both resets, the control/status register (offset 0x0B) reads 0x40 and the capture register (offset 0x0C) reads 0x00. All outputs are low.
- R2: The counter advances once every 32 clocks and runs from 0 to 249 before wrapping to 0. A timebase event leaves it at 0.
- R3: Bit 5 of the control/status register (long period) selects the timebase. When it is 0, the timebase flag (bit 3) sets every 8000 clocks. When it is 1, the flag sets every 16000 clocks.
- R4: A read of the control/status register clears the timebase flag. Writing bit 3 has no effect.
- R5: When the capture flag (bit 6) is clear, a rising or falling edge on `cap_pin` stores the counter value in the capture register and sets the capture flag. The counter is sampled two clocks after the pin changes.
- R6: While the capture flag is set, edges on `cap_pin` leave the capture register unchanged.
- R7: Only a read of the capture register clears the capture flag. Writing bit 6 has no effect, and writes to offset 0x0C change nothing.
- R8: `cap_irq` equals bit 7 (capture enable) AND bit 6. `tb_irq` equals bit 4 (timebase enable) AND bit 3.
- R9: Writing 1 to bit 2 (reset cause) raises `wdg_reset_req` for exactly one cycle after the write edge and sets bit 2.
- R10: Bit 2 keeps its value through `rst_n`, and `lvd_rst_n` clears it. All other bits return to their reset values on `rst_n`.
- R11: Writing 0 to bit 2 clears it only if the control/status register was read after the last write to it. Otherwise the bit is unchanged.
- R12: Every 16000 clocks a watchdog period ends. If bit 1 (enable) is 1 and bit 0 (delay) is 0, `wdg_reset_req` pulses. If bit 0 is 1, no pulse is issued and bit 0 clears.
- R13: Writing 1 to bit 0 sets it. Writing 0 to bit 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| lvd_rst_n | input | 1 | Asynchronous low-voltage reset, active low; clears the reset-cause flag |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_irq | output | 1 | Capture interrupt request |
| tb_irq | output | 1 | Timebase interrupt request |
| wdg_reset_req | output | 1 | One-cycle reset request |

## Verification
The assertions check the following on every cycle:
- both interrupt outputs agree with the flag and enable bits read on the bus;
- a forcing write is always followed by a request pulse that has the cause flag set;
- the capture register is frozen while its flag is pending;
- a capture read always clears that flag;
- the timebase flag changes only on a timebase event or a status read;
- the delay bit is sticky between period ends.

Only the directed scenarios show the exact captured counter values, the 8000 and 16000 clock intervals, the watchdog period, and how the cause flag behaves across both reset inputs and the read-before-clear rule.

// File: rtl/ltw_pkg.sv
`timescale 1ns/1ps
package ltw_pkg;
  localparam int unsigned CSR_OFS = 11;
  localparam int unsigned CAP_OFS = 12;
  localparam int B_CAP_IE  = 7;
  localparam int B_CAP_F   = 6;
  localparam int B_TB_LONG = 5;
  localparam int B_TB_IE   = 4;
  localparam int B_TB_F    = 3;
  localparam int B_WD_CAUSE = 2;
  localparam int B_WD_EN   = 1;
  localparam int B_WD_HOLD = 0;
endpackage

// File: rtl/ltw_timebase.sv
`timescale 1ns/1ps
module ltw_timebase #(
  parameter int PRESC    = 32,
  parameter int TB_STEPS = 250,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_sel,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             flag
);
  localparam int PRE_W = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TB_STEPS - 1);

  logic [PRE_W-1:0] pre_q;
  logic             step, wrap, half_q;

  assign step = (pre_q == PRE_LAST);
  assign wrap = step && (cnt == CNT_LAST);
  assign tick = wrap && (!long_sel || half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt    <= '0;
      half_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      pre_q <= step ? '0 : pre_q + 1'b1;
      if (wrap)      cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
      if (wrap) half_q <= ~half_q;
      if (tick)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ltw_capture.sv
`timescale 1ns/1ps
module ltw_capture #(
  parameter int CNT_W = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] value,
  output logic             flag
);
  logic [SYNC:0] sh_q;
  logic          edge_seen;

  assign edge_seen = sh_q[SYNC] ^ sh_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      value <= '0;
      flag  <= 1'b1;
    end else begin
      sh_q <= {sh_q[SYNC-1:0], pin};
      if (rd_clr) begin
        flag <= 1'b0;
      end else if (edge_seen && !flag) begin
        flag  <= 1'b1;
        value <= cnt;
      end
    end
  end
endmodule

// File: rtl/ltw_watchdog.sv
`timescale 1ns/1ps
module ltw_watchdog #(
  parameter int PERIOD = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvd_rst_n,
  input  logic en,
  input  logic hold_set,
  input  logic force_rst,
  input  logic cause_clr,
  output logic hold,
  output logic cause,
  output logic req,
  output logic pend
);
  localparam int WD_W = $clog2(PERIOD);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(PERIOD - 1);

  logic [WD_W-1:0] cnt_q;
  logic            fire;

  assign pend = (cnt_q == WD_LAST);
  assign fire = force_rst || (pend && en && !hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hold  <= 1'b0;
      req   <= 1'b0;
    end else begin
      cnt_q <= pend ? '0 : cnt_q + 1'b1;
      req   <= fire;
      if (pend)          hold <= 1'b0;
      else if (hold_set) hold <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge lvd_rst_n) begin
    if (!lvd_rst_n)     cause <= 1'b0;
    else if (fire)      cause <= 1'b1;
    else if (cause_clr) cause <= 1'b0;
  end
endmodule

// File: rtl/lite_timer_wdg.sv
`timescale 1ns/1ps
module lite_timer_wdg #(
  parameter int ADDR_W    = 4,
  parameter int PRESC     = 32,
  parameter int TB_STEPS  = 250,
  parameter int CNT_W     = 8,
  parameter int WD_PERIOD = 16000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvd_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cap_pin,
  output logic              cap_irq,
  output logic              tb_irq,
  output logic              wdg_reset_req
);
  import ltw_pkg::*;
  localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_OFS);
  localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_OFS);

  logic csr_hit, cap_hit, csr_rd, csr_wr, cap_rd;
  logic cap_ie_q, tb_long_q, tb_ie_q, wd_en_q, armed_q;
  logic [CNT_W-1:0] cnt, cap_value;
  logic cap_flag, tb_flag, tb_tick;
  logic wd_hold, wd_cause, wd_pend;
  logic [7:0] csr_view;
  logic unused_wbits;

  assign csr_hit = bus_sel && (bus_addr == CSR_A);
  assign cap_hit = bus_sel && (bus_addr == CAP_A);
  assign csr_rd  = csr_hit && !bus_wr;
  assign csr_wr  = csr_hit && bus_wr;
  assign cap_rd  = cap_hit && !bus_wr;
  assign unused_wbits = ^{bus_wdata[B_CAP_F], bus_wdata[B_TB_F]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ie_q  <= 1'b0;
      tb_long_q <= 1'b0;
      tb_ie_q   <= 1'b0;
      wd_en_q   <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (csr_wr) begin
        cap_ie_q  <= bus_wdata[B_CAP_IE];
        tb_long_q <= bus_wdata[B_TB_LONG];
        tb_ie_q   <= bus_wdata[B_TB_IE];
        wd_en_q   <= bus_wdata[B_WD_EN];
      end
      if (csr_rd)      armed_q <= 1'b1;
      else if (csr_wr) armed_q <= 1'b0;
    end
  end

  ltw_timebase #(.PRESC(PRESC), .TB_STEPS(TB_STEPS), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .long_sel(tb_long_q), .flag_clr(csr_rd),
    .cnt(cnt), .tick(tb_tick), .flag(tb_flag)
  );

  ltw_capture #(.CNT_W(CNT_W), .SYNC(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .cnt(cnt), .rd_clr(cap_rd),
    .value(cap_value), .flag(cap_flag)
  );

  ltw_watchdog #(.PERIOD(WD_PERIOD)) u_wd (
    .clk(clk), .rst_n(rst_n), .lvd_rst_n(lvd_rst_n), .en(wd_en_q),
    .hold_set(csr_wr && bus_wdata[B_WD_HOLD]),
    .force_rst(csr_wr && bus_wdata[B_WD_CAUSE]),
    .cause_clr(csr_wr && !bus_wdata[B_WD_CAUSE] && armed_q),
    .hold(wd_hold), .cause(wd_cause), .req(wdg_reset_req), .pend(wd_pend)
  );

  always_comb begin
    csr_view = '0;
    csr_view[B_CAP_IE]   = cap_ie_q;
    csr_view[B_CAP_F]    = cap_flag;
    csr_view[B_TB_LONG]  = tb_long_q;
    csr_view[B_TB_IE]    = tb_ie_q;
    csr_view[B_TB_F]     = tb_flag;
    csr_view[B_WD_CAUSE] = wd_cause;
    csr_view[B_WD_EN]    = wd_en_q;
    csr_view[B_WD_HOLD]  = wd_hold;
  end

  always_comb begin
    if (bus_addr == CSR_A)      bus_rdata = csr_view;
    else if (bus_addr == CAP_A) bus_rdata = 8'(cap_value);
    else                        bus_rdata = 8'h00;
  end

  assign cap_irq = cap_ie_q && cap_flag;
  assign tb_irq  = tb_ie_q && tb_flag;
endmodule

// File: rtl/ltw_checker.sv
`timescale 1ns/1ps
module ltw_checker #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              cap_irq,
  input logic              tb_irq,
  input logic              wdg_reset_req,
  input logic [CNT_W-1:0]  cap_value,
  input logic              cap_flag,
  input logic              tb_flag,
  input logic              tb_tick,
  input logic              wd_cause,
  input logic              wd_hold,
  input logic              wd_pend
);
  localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(ltw_pkg::CSR_OFS);
  localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(ltw_pkg::CAP_OFS);

  logic c_csr_rd, c_csr_wr, c_cap_rd;
  assign c_csr_rd = bus_sel && !bus_wr && (bus_addr == CSR_A);
  assign c_csr_wr = bus_sel && bus_wr && (bus_addr == CSR_A);
  assign c_cap_rd = bus_sel && !bus_wr && (bus_addr == CAP_A);

  a_r8_cap_irq: assert property (@(posedge clk) disable iff (!rst_n)
    c_csr_rd |-> (cap_irq == (bus_rdata[7] && bus_rdata[6])));
  a_r8_tb_irq: assert property (@(posedge clk) disable iff (!rst_n)
    c_csr_rd |-> (tb_irq == (bus_rdata[4] && bus_rdata[3])));
  a_r9_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (c_csr_wr && bus_wdata[2]) |=> wdg_reset_req);
  a_r9_req_with_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_reset_req |-> wd_cause);
  a_r6_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !c_cap_rd) |=> $stable(cap_value));
  a_r7_cap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    c_cap_rd |=> !cap_flag);
  a_r4_tb_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_tick && !c_csr_rd) |=> (tb_flag == $past(tb_flag)));
  a_r13_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_hold && !wd_pend) |=> wd_hold);
  a_r12_held_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_pend && wd_hold && !(c_csr_wr && bus_wdata[2])) |=> !wdg_reset_req);
endmodule

bind lite_timer_wdg ltw_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cap_irq(cap_irq), .tb_irq(tb_irq), .wdg_reset_req(wdg_reset_req),
  .cap_value(cap_value), .cap_flag(cap_flag), .tb_flag(tb_flag),
  .tb_tick(tb_tick), .wd_cause(wd_cause), .wd_hold(wd_hold), .wd_pend(wd_pend)
);

// File: tb/lite_timer_wdg_bench.sv
`timescale 1ns/1ps
module lite_timer_wdg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, lvd_rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cap_pin = 1'b0;
  logic cap_irq, tb_irq, wdg_reset_req;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] rd;

  localparam logic [3:0] CSR = 4'hB;
  localparam logic [3:0] CAP = 4'hC;

  always #4 clk = ~clk;

  lite_timer_wdg u_lite_timer_wdg (
    .clk(clk), .rst_n(rst_n), .lvd_rst_n(lvd_rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_pin(cap_pin), .cap_irq(cap_irq),
    .tb_irq(tb_irq), .wdg_reset_req(wdg_reset_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_tb(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tb_irq && n < 20000);
  endtask

  task automatic t_reset;
    bread(CSR, rd); chk("R1 csr", rd, 8'h40);
    bread(CAP, rd); chk("R1 cap", rd, 8'h00);
    chk("R1 irqs", {cap_irq, tb_irq, wdg_reset_req}, 0);
  endtask

  task automatic t_capture;
    int n;
    bread(CAP, rd);
    bread(CSR, rd); chk("R7 cap flag cleared by cap read", rd[6], 0);
    bwrite(CSR, 8'hD0);
    bread(CSR, rd); chk("R7 bit6 write ignored", rd[6], 0);
    bwrite(CAP, 8'hFF);
    bread(CAP, rd); chk("R7 cap reg read-only", rd, 8'h00);
    bread(CSR, rd);
    wait_tb(n);
    repeat (100) @(negedge clk);
    cap_pin = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 cap_irq set", cap_irq, 1);
    bread(CSR, rd); chk("R5 flag set after rising edge", rd[6], 1);
    cap_pin = 1'b0; repeat (10) @(negedge clk);
    cap_pin = 1'b1; repeat (10) @(negedge clk);
    bread(CAP, rd); chk("R2 R5 rising capture value", rd, 3);
    chk("R6 value unchanged after blocked edges", rd, 3);
    chk("R8 cap_irq clear after read", cap_irq, 0);
    bread(CSR, rd);
    wait_tb(n);
    repeat (300) @(negedge clk);
    cap_pin = 1'b0;
    repeat (5) @(negedge clk);
    bread(CAP, rd); chk("R2 R5 falling capture value", rd, 9);
  endtask

  task automatic t_timebase;
    int n;
    bwrite(CSR, 8'h10);
    bread(CSR, rd);
    wait_tb(n);
    chk("R8 tb_irq high", tb_irq, 1);
    bread(CSR, rd); chk("R3 flag visible", rd[3], 1);
    chk("R4 read clears flag", tb_irq, 0);
    bwrite(CSR, 8'h18);
    bread(CSR, rd); chk("R4 bit3 write ignored", rd[3], 0);
    wait_tb(n); chk("R3 short period", n + 6, 8000);
    bwrite(CSR, 8'h30);
    bread(CSR, rd);
    wait_tb(n);
    bread(CSR, rd);
    wait_tb(n); chk("R3 long period", n + 2, 16000);
    bwrite(CSR, 8'h00);
  endtask

  task automatic t_watchdog;
    bit seen = 1'b0;
    int pulses = 0;
    bwrite(CSR, 8'h02);
    for (int i = 0; i < 17000 && !seen; i++) begin
      @(negedge clk); if (wdg_reset_req) seen = 1'b1;
    end
    chk("R12 period-end request", seen, 1);
    @(negedge clk); chk("R12 request is one cycle", wdg_reset_req, 0);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    bwrite(CSR, 8'h00);
    bread(CSR, rd); chk("R10 R11 cause kept across rst_n and unarmed write", rd, 8'h44);
    bwrite(CSR, 8'h00);
    bread(CSR, rd); chk("R11 cause cleared after read", rd[2], 0);
    bwrite(CSR, 8'h03);
    for (int i = 0; i < 16100; i++) begin
      @(negedge clk); if (wdg_reset_req) pulses++;
    end
    chk("R12 delayed: no request", pulses, 0);
    bread(CSR, rd); chk("R12 delay bit cleared at period end", rd[1:0], 2'b10);
    bwrite(CSR, 8'h01);
    bwrite(CSR, 8'h00);
    bread(CSR, rd); chk("R13 writing 0 keeps delay bit", rd[0], 1);
    bwrite(CSR, 8'h04);
    chk("R9 forced request", wdg_reset_req, 1);
    @(negedge clk); chk("R9 forced request one cycle", wdg_reset_req, 0);
    bread(CSR, rd); chk("R9 cause set by force", rd[2], 1);
    @(negedge clk); lvd_rst_n = 1'b0; @(negedge clk); lvd_rst_n = 1'b1;
    bread(CSR, rd); chk("R10 low-voltage reset clears cause", rd[2], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; lvd_rst_n = 1'b1;
    t_reset();
    t_capture();
    t_timebase();
    t_watchdog();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog timeout actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule